// File: doc/BRIEF.md
# Instruction Dispatch Group Former

This block sits between instruction decode and the dispatch stage of an out-of-order core. Decoded instruction records arrive in aligned blocks of eight and are written into a 32-entry circular fetch buffer. Each cycle the block scans the oldest records in program order and cuts them into one dispatch group. A group has four non-branch slots and one optional branch slot. The records of one group then travel together through dispatch and retirement.

Several rules end a group early. A branch always closes it. A microcoded instruction sits alone in its group. A cracked instruction needs two adjacent slots and is never split across groups. At most two condition-register writers may share a group. A write to an unrenamed special register is the last member of its group. The group also ends when the buffer has no more records.

The formed group is held in an output register and offered with a valid/ready handshake. Two states control this register. `ST_IDLE` means no group is held. `ST_OFFER` means a group is presented. The transitions are:
- `T_FORM` (idle to offer, a group could be formed).
- `T_NEXT` (offer to offer, accepted and the next group loaded in the same cycle).
- `T_DRAIN` (offer to idle, accepted with nothing left to form).
- `T_STALL` (offer held, ready low).
- `T_FLUSH` (any state to idle on flush).

Top module: `dispatch_grouper`

## Requirements
- R1: A group holds at most four non-branch slots, filled contiguously from slot 0 in program order, plus at most one branch in the separate branch slot.
- R2: A record is 13 bits: bit 0 branch, bit 1 cracked, bit 2 microcoded, bit 3 condition-register writer, bit 4 special-register writer, bits 12:5 tag. A record with bit 0 set is a branch, and its other flag bits are ignored. A branch always ends its group, so two plain records followed by a branch form one three-instruction group.
- R3: The buffer holds 32 records and accepts a whole block of eight on `fill_valid` only while `fill_ready` is high. `fill_ready` is high exactly when at least eight entries are free and `flush` is low. A block offered while `fill_ready` is low is dropped.
- R4: When the buffer runs out of records, the records gathered so far are emitted as a group without waiting for more.
- R5: A microcoded record forms a group alone (slot 0 only, no branch). When it is not the oldest remaining record, the group ends before it.
- R6: A cracked record takes two adjacent slots, both carrying the record, with the tail bit set on the second. If fewer than two slots remain, it is deferred whole to the next group.
- R7: A special-register writer is placed in the group and ends it.
- R8: No group contains more than two condition-register writers; a third one starts the next group.
- R9: At most one group is emitted per cycle. While `grp_valid` is high and `grp_ready` is low, the group is held stable and no records are consumed.
- R10: `flush` empties the buffer, drops any held group, and is followed by `grp_valid` low.
- R11: After reset, `grp_valid` is low and `fill_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard buffered records and the held group |
| fill_valid | input | 1 | A block of eight records is offered |
| fill_data | input | 104 | Block of eight records, oldest in bits 12:0 |
| fill_ready | output | 1 | At least eight free entries and no flush |
| grp_ready | input | 1 | Downstream accepts the presented group |
| grp_valid | output | 1 | A group is presented |
| grp_slot_valid | output | 4 | Per non-branch slot occupancy |
| grp_slot_tail | output | 4 | Slot holds the second half of a cracked record |
| grp_slot_data | output | 52 | Four slot records, slot 0 in bits 12:0 |
| grp_br_valid | output | 1 | Branch slot occupied |
| grp_br_data | output | 13 | Branch slot record |

## Verification
Bad read-pointer or count state shows at the ports on the very next presented group: a record is lost, duplicated or reordered, or `fill_ready` disagrees with the number of free entries. A bench model that tracks the record queue therefore exposes it within one or two cycles. A wrong cut rule shows up as a group whose slot pattern or branch slot differs from the model in the same cycle the group is offered. Stall and flush errors appear as a presented group that changes while ready is low, or that survives a flush.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
    localparam int TAG_W  = 8;
    localparam int SLOTS  = 4;
    localparam int WIN    = SLOTS + 1;
    localparam int TAKE_W = $clog2(WIN + 1);
    localparam int CR_CAP = 2;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             spr;
        logic             crw;
        logic             mc;
        logic             ck;
        logic             br;
    } rec_t;

    localparam int REC_W = $bits(rec_t);
endpackage

// File: rtl/dgf_fetch_buf.sv
module dgf_fetch_buf
    import dgf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int BLK   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 fill_valid,
    input  logic [BLK*REC_W-1:0] fill_data,
    output logic                 fill_ready,
    input  logic [TAKE_W-1:0]    pop_n,
    output rec_t                 win [WIN],
    output logic [TAKE_W-1:0]    avail
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rec_t             mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             fill_acc;

    assign fill_ready = !flush && (cnt <= CNT_W'(DEPTH - BLK));
    assign fill_acc   = fill_valid && fill_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            if (fill_acc) wr_ptr <= wr_ptr + PTR_W'(BLK);
            cnt <= cnt - CNT_W'(pop_n) + (fill_acc ? CNT_W'(BLK) : CNT_W'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (fill_acc) begin
            for (int k = 0; k < BLK; k++)
                mem[wr_ptr + PTR_W'(k)] <= rec_t'(fill_data[k*REC_W +: REC_W]);
        end
    end

    always_comb begin
        for (int i = 0; i < WIN; i++)
            win[i] = mem[rd_ptr + PTR_W'(i)];
        avail = (cnt >= CNT_W'(WIN)) ? TAKE_W'(WIN) : TAKE_W'(cnt);
    end

    AST_POP_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_n) <= cnt);  // R4
endmodule

// File: rtl/dgf_group_scan.sv
module dgf_group_scan
    import dgf_pkg::*;
(
    input  rec_t              win [WIN],
    input  logic [TAKE_W-1:0] avail,
    output rec_t              slot_rec [SLOTS],
    output logic [SLOTS-1:0]  slot_vld,
    output logic [SLOTS-1:0]  slot_tail,
    output logic              br_vld,
    output rec_t              br_rec,
    output logic [TAKE_W-1:0] take
);
    always_comb begin
        int   used;
        int   crs;
        int   need;
        logic stop;
        used      = 0;
        crs       = 0;
        need      = 1;
        stop      = 1'b0;
        take      = '0;
        br_vld    = 1'b0;
        br_rec    = '0;
        slot_vld  = '0;
        slot_tail = '0;
        for (int j = 0; j < SLOTS; j++) slot_rec[j] = '0;
        for (int i = 0; i < WIN; i++) begin
            if (!stop && i < int'(avail)) begin
                if (win[i].br) begin
                    br_vld = 1'b1;
                    br_rec = win[i];
                    take   = TAKE_W'(i + 1);
                    stop   = 1'b1;
                end else if (win[i].mc) begin
                    if (i == 0) begin
                        slot_rec[0] = win[i];
                        slot_vld[0] = 1'b1;
                        take        = TAKE_W'(1);
                    end
                    stop = 1'b1;
                end else begin
                    need = win[i].ck ? 2 : 1;
                    if (used + need > SLOTS || (win[i].crw && crs >= CR_CAP)) begin
                        stop = 1'b1;
                    end else begin
                        for (int j = 0; j < SLOTS; j++) begin
                            if (j == used) begin
                                slot_rec[j] = win[i];
                                slot_vld[j] = 1'b1;
                            end
                            if (need == 2 && j == used + 1) begin
                                slot_rec[j]  = win[i];
                                slot_vld[j]  = 1'b1;
                                slot_tail[j] = 1'b1;
                            end
                        end
                        used = used + need;
                        if (win[i].crw) crs = crs + 1;
                        take = TAKE_W'(i + 1);
                        if (win[i].spr) stop = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dispatch_grouper.sv
module dispatch_grouper
    import dgf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int BLK   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   fill_valid,
    input  logic [BLK*REC_W-1:0]   fill_data,
    output logic                   fill_ready,
    input  logic                   grp_ready,
    output logic                   grp_valid,
    output logic [SLOTS-1:0]       grp_slot_valid,
    output logic [SLOTS-1:0]       grp_slot_tail,
    output logic [SLOTS*REC_W-1:0] grp_slot_data,
    output logic                   grp_br_valid,
    output logic [REC_W-1:0]       grp_br_data
);
    typedef enum logic {ST_IDLE, ST_OFFER} st_t;

    st_t               state;
    st_t               state_nx;
    rec_t              win [WIN];
    logic [TAKE_W-1:0] avail;
    logic [TAKE_W-1:0] take;
    logic [TAKE_W-1:0] pop_n;
    rec_t              s_rec [SLOTS];
    logic [SLOTS-1:0]  s_vld;
    logic [SLOTS-1:0]  s_tail;
    logic              s_bv;
    rec_t              s_br;
    logic              formed;
    logic              load;

    rec_t              g_slot [SLOTS];
    logic [SLOTS-1:0]  g_vld;
    logic [SLOTS-1:0]  g_tail;
    logic              g_bv;
    rec_t              g_br;

    dgf_fetch_buf #(.DEPTH(DEPTH), .BLK(BLK)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .fill_ready (fill_ready),
        .pop_n      (pop_n),
        .win        (win),
        .avail      (avail)
    );

    dgf_group_scan u_scan (
        .win       (win),
        .avail     (avail),
        .slot_rec  (s_rec),
        .slot_vld  (s_vld),
        .slot_tail (s_tail),
        .br_vld    (s_bv),
        .br_rec    (s_br),
        .take      (take)
    );

    assign formed = (take != '0);
    assign load   = !flush && formed && (state == ST_IDLE || grp_ready);
    assign pop_n  = load ? take : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions T_FORM, T_NEXT, T_DRAIN, T_STALL, T_FLUSH
    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (formed) state_nx = ST_OFFER;
                ST_OFFER: if (grp_ready) state_nx = formed ? ST_OFFER : ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // output group register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < SLOTS; j++) g_slot[j] <= '0;
            g_vld  <= '0;
            g_tail <= '0;
            g_bv   <= 1'b0;
            g_br   <= '0;
        end else if (load) begin
            g_slot <= s_rec;
            g_vld  <= s_vld;
            g_tail <= s_tail;
            g_bv   <= s_bv;
            g_br   <= s_br;
        end
    end

    assign grp_valid      = (state == ST_OFFER);
    assign grp_slot_valid = g_vld;
    assign grp_slot_tail  = g_tail;
    assign grp_br_valid   = g_bv;
    assign grp_br_data    = g_br;

    for (genvar j = 0; j < SLOTS; j++) begin : g_pack
        assign grp_slot_data[j*REC_W +: REC_W] = g_slot[j];
    end

    logic [2:0] cr_seen;
    always_comb begin
        cr_seen = '0;
        for (int j = 0; j < SLOTS; j++)
            if (g_vld[j] && !g_tail[j] && g_slot[j].crw) cr_seen = cr_seen + 3'd1;
    end

    AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (grp_slot_valid inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111})
                      && (grp_slot_valid != '0 || grp_br_valid));  // R1
    AST_MCODE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && g_slot[0].mc && g_vld[0]) |-> (grp_slot_valid == 4'b0001 && !grp_br_valid));  // R5
    AST_CR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (cr_seen <= 3'(CR_CAP)));  // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !grp_ready && !flush) |=> (grp_valid && $stable(grp_slot_data)
            && $stable(grp_slot_valid) && $stable(grp_br_valid) && $stable(grp_br_data)));  // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !grp_valid);  // R10

    for (genvar j = 1; j < SLOTS; j++) begin : g_tail_chk
        AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_valid && grp_slot_tail[j]) |->
                (grp_slot_valid[j] && grp_slot_valid[j-1] && !grp_slot_tail[j-1] && g_slot[j-1].ck));  // R6
    end
endmodule

// File: tb/dispatch_grouper_test.sv
`timescale 1ns/1ps
module dispatch_grouper_test;
    import dgf_pkg::*;

    localparam int DEPTH = 32;
    localparam int BLK   = 8;
    localparam int P  = 0;
    localparam int BR = 1;
    localparam int CK = 2;
    localparam int MC = 4;
    localparam int CR = 8;
    localparam int SP = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   flush = 1'b0;
    logic                   fill_valid = 1'b0;
    logic [BLK*REC_W-1:0]   fill_data = '0;
    logic                   fill_ready;
    logic                   grp_ready = 1'b1;
    logic                   grp_valid;
    logic [SLOTS-1:0]       grp_slot_valid;
    logic [SLOTS-1:0]       grp_slot_tail;
    logic [SLOTS*REC_W-1:0] grp_slot_data;
    logic                   grp_br_valid;
    logic [REC_W-1:0]       grp_br_data;

    dispatch_grouper #(.DEPTH(DEPTH), .BLK(BLK)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .fill_valid     (fill_valid),
        .fill_data      (fill_data),
        .fill_ready     (fill_ready),
        .grp_ready      (grp_ready),
        .grp_valid      (grp_valid),
        .grp_slot_valid (grp_slot_valid),
        .grp_slot_tail  (grp_slot_tail),
        .grp_slot_data  (grp_slot_data),
        .grp_br_valid   (grp_br_valid),
        .grp_br_data    (grp_br_data)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    string cur = "R11";
    int    tagc = 1;
    bit    rnd_ready = 0;
    bit    done = 0;

    // behavioural reference model
    logic [REC_W-1:0] q[$];
    bit               e_v = 0;
    logic [3:0]       e_sv, e_st;
    logic [REC_W-1:0] e_sd [4];
    bit               e_bv;
    logic [REC_W-1:0] e_bd;

    always @(posedge clk) begin
        int room, used, crs, k;
        bit fin;
        logic [REC_W-1:0] rec;
        if (!rst_n || flush) begin
            q.delete();
            e_v = 0;
        end else begin
            room = DEPTH - q.size();
            if (!e_v || grp_ready) begin
                e_sv = 0; e_st = 0; e_bv = 0; used = 0; crs = 0; k = 0; fin = 0;
                while (!fin && k < q.size()) begin
                    rec = q[k];
                    if (rec[0]) begin
                        e_bv = 1; e_bd = rec; k++; fin = 1;
                    end else if (rec[2]) begin
                        if (k == 0) begin e_sd[0] = rec; e_sv[0] = 1; k = 1; end
                        fin = 1;
                    end else if (used + (rec[1] ? 2 : 1) > 4 || (rec[3] && crs == 2)) begin
                        fin = 1;
                    end else begin
                        e_sd[used] = rec; e_sv[used] = 1; used++;
                        if (rec[1]) begin e_sd[used] = rec; e_sv[used] = 1; e_st[used] = 1; used++; end
                        if (rec[3]) crs++;
                        k++;
                        if (rec[4]) fin = 1;
                    end
                end
                e_v = (k > 0);
                repeat (k) void'(q.pop_front());
            end
            if (fill_valid && room >= BLK)
                for (int j = 0; j < BLK; j++) q.push_back(fill_data[j*REC_W +: REC_W]);
        end
    end

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check("fill_ready", 64'(fill_ready), 64'((DEPTH - q.size() >= BLK) && !flush));
            check("grp_valid", 64'(grp_valid), 64'(e_v));
            if (e_v && grp_valid) begin
                check("slot_valid", 64'(grp_slot_valid), 64'(e_sv));
                check("slot_tail", 64'(grp_slot_tail), 64'(e_st));
                check("br_valid", 64'(grp_br_valid), 64'(e_bv));
                if (e_bv) check("br_data", 64'(grp_br_data), 64'(e_bd));
                for (int j = 0; j < 4; j++)
                    if (e_sv[j]) check("slot_data", 64'(grp_slot_data[j*REC_W +: REC_W]), 64'(e_sd[j]));
            end
        end
    end

    always @(negedge clk) if (rnd_ready) grp_ready = ($urandom % 3) != 0;

    function automatic logic [REC_W-1:0] mk(input int f);
        logic [REC_W-1:0] r;
        r = {TAG_W'(tagc), 5'(f)};
        tagc++;
        return r;
    endfunction

    task automatic send(input int f[8]);
        logic [BLK*REC_W-1:0] d;
        for (int k = 0; k < BLK; k++) d[k*REC_W +: REC_W] = mk(f[k]);
        forever begin
            @(negedge clk);
            if (fill_ready && !flush) begin
                fill_valid = 1; fill_data = d;
                @(negedge clk);
                fill_valid = 0;
                break;
            end
        end
    endtask

    task automatic drain(input int n);
        grp_ready = 1;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int f[8];
        // R11: reset state
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check("R11 reset grp_valid", 64'(grp_valid), 64'(0));
        check("R11 reset fill_ready", 64'(fill_ready), 64'(1));

        cur = "R2";  grp_ready = 0;
        send('{P, P, BR, P, P, P, P, BR | CK | MC}); drain(8);
        cur = "R1";  grp_ready = 0;
        send('{P, P, P, P, P, P, P, P}); send('{BR, P, P, P, P, BR, P, P}); drain(10);
        cur = "R4";
        send('{P, P, P, P, P, BR, P, P}); drain(8);
        cur = "R5";  grp_ready = 0;
        send('{P, MC, P, P, BR, MC, BR, MC}); drain(10);
        cur = "R6";  grp_ready = 0;
        send('{P, P, P, CK, CK, CK, P, CK}); send('{CK, P, CK, CK, P, P, CK, BR}); drain(14);
        cur = "R7";  grp_ready = 0;
        send('{P, SP, P, P, P, SP | CR, P, SP}); drain(10);
        cur = "R8";  grp_ready = 0;
        send('{CR, CR, CR, P, CR, CK | CR, CR, BR}); drain(10);

        cur = "R3";  grp_ready = 0;
        for (int b = 0; b < 4; b++) send('{P, P, P, P, P, P, P, P});
        @(negedge clk);
        check("R3 full buffer fill_ready", 64'(fill_ready), 64'(0));
        fill_valid = 1; fill_data = '1;
        repeat (2) @(negedge clk);
        fill_valid = 0;
        drain(24);

        cur = "R9";
        rnd_ready = 1;
        for (int b = 0; b < 6; b++) send('{P, CK, BR, CR, P, SP, P, MC});
        repeat (30) @(negedge clk);
        rnd_ready = 0;
        drain(10);

        cur = "R10"; grp_ready = 0;
        send('{P, P, P, P, P, P, P, P}); send('{P, BR, P, P, P, P, P, P});
        pulse_flush();
        @(negedge clk);
        check("R10 flush grp_valid", 64'(grp_valid), 64'(0));
        drain(4);
        check("R10 flush buffer empty", 64'(grp_valid), 64'(0));

        cur = "R1";
        rnd_ready = 1;
        for (int b = 0; b < 200; b++) begin
            for (int k = 0; k < 8; k++) begin
                case ($urandom % 16)
                    8:       f[k] = BR;
                    9:       f[k] = CK;
                    10:      f[k] = MC;
                    11:      f[k] = CR;
                    12:      f[k] = SP;
                    13:      f[k] = CK | CR;
                    14:      f[k] = CR | SP;
                    15:      f[k] = BR | CR;
                    default: f[k] = P;
                endcase
            end
            send(f);
            if ($urandom % 40 == 0) pulse_flush();
        end
        rnd_ready = 0;
        drain(40);
        finish_run();
    end
endmodule